// File: doc/BRIEF.md
# Serial Transceiver with Shared Completion Interrupt

This block is an asynchronous serial transmitter and receiver behind a four-address byte register bank. A mode register holds separate enables for the two directions and a bit that mutes the interrupt for frames that arrive damaged. Writing a byte to the data address starts a frame on the serial output. The receiver oversamples its serial input, votes on each bit near its centre, and leaves every byte it assembles in the receive data register, even when that frame is damaged.

Both directions drive a single interrupt line. Two sticky flag bits record which direction completed. Software reads the flag register to find the cause and writes ones to clear the flags. A shared divider produces the oversampling tick. Each bit lasts `OVS` ticks.

Both serial engines run the same four-state machine. The transitions are:
- IDLE→START: on a start request, or, for the receiver, on a low line sample.
- START→DATA: after one bit time. The receiver takes START→IDLE instead if the centre vote finds the line high.
- DATA→DATA: for each of the eight bits.
- DATA→STOP: after bit 7.
- STOP→IDLE: after the stop bit. For the receiver this happens at its centre vote.

Clearing a direction's enable forces its machine to IDLE.

Top module: `uart_shared_irq`

## Requirements
- R1: After reset the serial output is high and `irq` is low. The mode register (address 0), status (address 2) and flags (address 3) all read 0.
- R2: Mode bit 7 is the transmit enable. With it set, writing address 1 sends a frame: one low start bit, then eight data bits with the LSB first, then one high stop bit. Each bit lasts DIV*OVS clocks.
- R3: A write to address 1 while mode bit 7 is 0 sends nothing, and the serial output stays high.
- R4: The end of a transmitted frame sets flag bit 0 (address 3), and `irq` goes high.
- R5: Mode bit 6 is the receive enable. With it set, a received frame puts its byte in the receive data register (a read of address 1) and sets flag bit 1.
- R6: While mode bit 6 is 0, frames on `rxd` set no flag and leave the receive data register unchanged.
- R7: A low pulse on `rxd` that is shorter than half a bit time is rejected as a glitch. It sets no flag and changes no status bit.
- R8: A stop bit sampled low sets status bit 0 (framing error). The byte of that frame is still stored.
- R9: With mode bit 1 at 0, a frame with an error still sets flag bit 1. With mode bit 1 at 1, that frame sets no flag, but its byte is still stored.
- R10: If a frame completes while the previous byte is unread, status bit 1 (overrun) is set and the new byte replaces the old one.
- R11: Reading the receive data register clears status bits 0 and 1.
- R12: `irq` is the OR of the two flags. Writing 1 to a flag bit position clears that flag, and writing 0 leaves it unchanged. An event in the same cycle as its clear leaves the flag set.
- R13: Status bit 2 reads 1 while a frame is being sent. A write to address 1 during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (a read of address 1 has side effects) |
| rd_data | output | 8 | Register read data, combinational from `addr` |
| rxd | input | 1 | Serial input, idles high |
| txd | output | 1 | Serial output, idles high |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench builds the block with DIV=2 and OVS=16. Each bit is then 32 clocks and a frame is about 320 clocks, so dozens of frames and every error path fit within a short run. In loopback, where the serial output feeds the serial input, the table of bytes exercises the transmitter and the receiver together. Directed frames driven by the bench then reach glitches, damaged stop bits, muted interrupts, overruns and the write-one-to-clear behaviour of the flags.

// File: rtl/uart_pkg.sv
package uart_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_DATA  = 2'd2,
        S_STOP  = 2'd3
    } ser_state_t;

    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_FLAG = 2'd3;

    localparam int B_TXON    = 7;
    localparam int B_RXON    = 6;
    localparam int B_ERRMUTE = 1;
endpackage

// File: rtl/uart_tick.sv
module uart_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == TOP) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] din,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    ser_state_t    state;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= '0;
            done  <= 1'b0;
        end else if (!en) begin
            state <= S_IDLE;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    sh    <= din;
                    cnt   <= '0;
                    state <= S_START;
                end
                S_START: if (tick) begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        bitn  <= '0;
                        state <= S_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                S_DATA: if (tick) begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        sh  <= {1'b0, sh[7:1]};
                        if (bitn == 3'd7) state <= S_STOP;
                        else bitn <= bitn + 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                S_STOP: if (tick) begin
                    if (cnt == LAST) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            S_IDLE:  txd = 1'b1;
            S_START: txd = 1'b0;
            S_DATA:  txd = sh[0];
            S_STOP:  txd = 1'b1;
            default: txd = 1'b1;
        endcase
        busy = (state != S_IDLE);
    end

    // R2: a finished frame always ends on a high stop level
    a_r2_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> txd);
    // R13: a start request while busy does not reload the shift register
    a_r13_busy_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == S_DATA && !tick) |=> $stable(sh));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd,
    output logic [7:0] data,
    output logic       ferr,
    output logic       done
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] V_LO = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] V_HI = CW'(OVS / 2 + 1);

    ser_state_t    state;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    shreg;
    logic [1:0]    ones;
    logic [1:0]    sync;
    logic          line;
    logic          maj;

    assign line = sync[1];
    assign maj  = (ones + {1'b0, line}) >= 2'd2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            ones  <= '0;
            data  <= '0;
            ferr  <= 1'b0;
            done  <= 1'b0;
        end else if (!en) begin
            state <= S_IDLE;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    S_IDLE: if (!line) begin
                        cnt   <= CW'(1);
                        ones  <= '0;
                        state <= S_START;
                    end
                    S_START, S_DATA, S_STOP: begin
                        if (cnt >= V_LO && cnt < V_HI) ones <= ones + {1'b0, line};
                        if (cnt == LAST) cnt <= '0;
                        else             cnt <= cnt + 1'b1;
                        if (cnt == V_HI) begin
                            if (state == S_START && maj) state <= S_IDLE;
                            if (state == S_DATA) shreg <= {maj, shreg[7:1]};
                            if (state == S_STOP) begin
                                data  <= shreg;
                                ferr  <= !maj;
                                done  <= 1'b1;
                                state <= S_IDLE;
                            end
                        end
                        if (cnt == LAST) begin
                            ones <= '0;
                            if (state == S_START) begin
                                bitn  <= '0;
                                state <= S_DATA;
                            end else if (state == S_DATA) begin
                                if (bitn == 3'd7) state <= S_STOP;
                                else bitn <= bitn + 1'b1;
                            end
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R6: a disabled receiver cannot report a frame
    a_r6_off_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !done);
    // R8: completion pulses last one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/uart_shared_irq.sv
module uart_shared_irq
    import uart_pkg::*;
#(
    parameter int DIV = 4,
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    logic       tick;
    logic [7:0] mode;
    logic       tx_busy, tx_done;
    logic [7:0] rx_byte;
    logic       rx_ferr, rx_done;
    logic       rx_full, ferr_q, ovr_q;
    logic [1:0] flags;
    logic       rd_rx, ovr_now, rx_bad, rx_set;
    logic [1:0] clr;

    uart_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    uart_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(mode[B_TXON]), .tick(tick),
        .start(wr_en && addr == A_DATA), .din(wr_data),
        .txd(txd), .busy(tx_busy), .done(tx_done));

    uart_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(mode[B_RXON]), .tick(tick), .rxd(rxd),
        .data(rx_byte), .ferr(rx_ferr), .done(rx_done));

    always_comb begin
        rd_rx   = rd_en && addr == A_DATA;
        ovr_now = rx_full && !rd_rx;
        rx_bad  = rx_ferr || ovr_now;
        rx_set  = rx_done && !(rx_bad && mode[B_ERRMUTE]);
        clr     = (wr_en && addr == A_FLAG) ? wr_data[1:0] : 2'b00;
        irq     = |flags;
        unique case (addr)
            A_MODE:  rd_data = mode;
            A_DATA:  rd_data = rx_byte;
            A_STAT:  rd_data = {5'b0, tx_busy, ovr_q, ferr_q};
            A_FLAG:  rd_data = {6'b0, flags};
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode    <= '0;
            flags   <= '0;
            rx_full <= 1'b0;
            ferr_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (wr_en && addr == A_MODE) mode <= wr_data;
            flags[0] <= tx_done | (flags[0] & ~clr[0]);
            flags[1] <= rx_set  | (flags[1] & ~clr[1]);
            if (rx_done) begin
                rx_full <= 1'b1;
                ferr_q  <= rx_ferr | (ferr_q & ~rd_rx);
                ovr_q   <= ovr_now | (ovr_q & ~rd_rx);
            end else if (rd_rx) begin
                rx_full <= 1'b0;
                ferr_q  <= 1'b0;
                ovr_q   <= 1'b0;
            end
        end
    end

    // R4: a finished transmit frame is always visible in flag bit 0
    a_r4_tx_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> flags[0]);
    // R9: a muted damaged frame leaves a clear receive flag clear
    a_r9_mute_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ferr && mode[B_ERRMUTE] && !flags[1]) |=> !flags[1]);
    // R12: a set flag survives any cycle without a matching clear
    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !(wr_en && addr == A_FLAG && wr_data[1])) |=> flags[1]);
    // R11: reading received data leaves both error bits clear
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !rx_done) |=> (!ferr_q && !ovr_q));
    // R12: interrupt follows the flags
    a_r12_irq_low_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[0] && !flags[1]) |-> !irq);
endmodule

// File: tb/uart_shared_irq_tb.sv
module uart_shared_irq_tb;
    localparam int DIV = 2;
    localparam int OVS = 16;
    localparam int BIT = DIV * OVS;
    localparam logic [7:0] VEC [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A,
                                       8'h01, 8'h80, 8'h3C, 8'hC3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       txd, irq;
    logic       loop = 1'b0;
    logic       rxd_drv = 1'b1;
    logic       rxd;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;
    assign rxd = loop ? txd : rxd_drv;

    uart_shared_irq #(.DIV(DIV), .OVS(OVS)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rxd(rxd), .txd(txd), .irq(irq));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic capture_tx(output logic [7:0] b, output logic stopb, output logic seen);
        seen = 1'b0; b = '0; stopb = 1'b0;
        for (int i = 0; i < 40 * BIT; i++) begin
            @(negedge clk);
            if (!txd) begin seen = 1'b1; break; end
        end
        if (seen) begin
            repeat (BIT / 2) @(negedge clk);
            for (int k = 0; k < 8; k++) begin
                repeat (BIT) @(negedge clk);
                b[k] = txd;
            end
            repeat (BIT) @(negedge clk);
            stopb = txd;
        end
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stopb);
        @(negedge clk); rxd_drv = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd_drv = b[k];
            repeat (BIT) @(negedge clk);
        end
        rxd_drv = stopb;
        repeat (BIT) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    task automatic count_low(input int cycles, output int lows);
        lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, got;
        logic       stopb, seen;
        int         lows;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", {7'b0, txd}, 8'h01);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        bus_rd(2'd0, v); chk("R1 mode", v, 8'h00);
        bus_rd(2'd2, v); chk("R1 status", v, 8'h00);
        bus_rd(2'd3, v); chk("R1 flags", v, 8'h00);

        // Table walk in loopback: R2, R4, R5, R12
        loop = 1'b1;
        bus_wr(2'd0, 8'hC0);
        foreach (VEC[i]) begin
            bus_wr(2'd1, VEC[i]);
            capture_tx(got, stopb, seen);
            chk("R2 frame seen", {7'b0, seen}, 8'h01);
            chk("R2 tx bits", got, VEC[i]);
            chk("R2 stop high", {7'b0, stopb}, 8'h01);
            repeat (40) @(negedge clk);
            bus_rd(2'd3, v); chk("R4 R5 flags", v, 8'h03);
            chk("R12 irq set", {7'b0, irq}, 8'h01);
            bus_rd(2'd1, v); chk("R5 rx byte", v, VEC[i]);
            bus_rd(2'd2, v); chk("R5 status clean", v, 8'h00);
            bus_wr(2'd3, 8'h03);
            @(negedge clk);
            chk("R12 irq cleared", {7'b0, irq}, 8'h00);
        end
        loop = 1'b0;

        // R3 transmit disabled
        bus_wr(2'd0, 8'h40);
        bus_wr(2'd1, 8'h55);
        count_low(12 * BIT, lows);
        chk("R3 txd low samples", lows[7:0], 8'h00);
        bus_rd(2'd3, v); chk("R3 flags", v, 8'h00);

        // R13 busy status and ignored write
        bus_wr(2'd0, 8'hC0);
        bus_wr(2'd1, 8'h96);
        bus_rd(2'd2, v); chk("R13 busy bit", v & 8'h04, 8'h04);
        bus_wr(2'd1, 8'h11);
        capture_tx(got, stopb, seen);
        chk("R13 first byte kept", got, 8'h96);
        count_low(12 * BIT, lows);
        chk("R13 no second frame", lows[7:0], 8'h00);
        bus_rd(2'd2, v); chk("R13 idle", v & 8'h04, 8'h00);

        // R12 write-one-to-clear per bit, R5 direct receive
        send_rx(8'h3E, 1'b1);
        bus_rd(2'd3, v); chk("R12 both flags", v, 8'h03);
        bus_wr(2'd3, 8'h00);
        bus_rd(2'd3, v); chk("R12 zero write keeps", v, 8'h03);
        bus_wr(2'd3, 8'h01);
        bus_rd(2'd3, v); chk("R12 clear tx only", v, 8'h02);
        chk("R12 irq from rx flag", {7'b0, irq}, 8'h01);
        bus_wr(2'd3, 8'h02);
        bus_rd(2'd3, v); chk("R12 all clear", v, 8'h00);
        chk("R12 irq low", {7'b0, irq}, 8'h00);
        bus_rd(2'd1, v); chk("R5 rx byte direct", v, 8'h3E);

        // R6 receive disabled
        bus_wr(2'd0, 8'h80);
        send_rx(8'h77, 1'b1);
        bus_rd(2'd3, v); chk("R6 flags", v, 8'h00);
        bus_rd(2'd1, v); chk("R6 data unchanged", v, 8'h3E);

        // R7 glitch rejection
        bus_wr(2'd0, 8'hC0);
        @(negedge clk); rxd_drv = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (12 * BIT) @(negedge clk);
        bus_rd(2'd3, v); chk("R7 flags", v, 8'h00);
        bus_rd(2'd2, v); chk("R7 status", v, 8'h00);

        // R8, R9 (not muted), R11
        send_rx(8'hA1, 1'b0);
        bus_rd(2'd3, v); chk("R9 flag unmuted", v, 8'h02);
        bus_rd(2'd2, v); chk("R8 framing bit", v, 8'h01);
        bus_rd(2'd1, v); chk("R8 byte kept", v, 8'hA1);
        bus_rd(2'd2, v); chk("R11 cleared", v, 8'h00);
        bus_wr(2'd3, 8'h03);

        // R9 muted
        bus_wr(2'd0, 8'hC2);
        send_rx(8'h4B, 1'b0);
        bus_rd(2'd3, v); chk("R9 muted flag", v, 8'h00);
        bus_rd(2'd2, v); chk("R9 framing latched", v, 8'h01);
        bus_rd(2'd1, v); chk("R9 byte kept", v, 8'h4B);

        // R10 overrun
        bus_wr(2'd0, 8'hC0);
        send_rx(8'h10, 1'b1);
        send_rx(8'h20, 1'b1);
        bus_rd(2'd2, v); chk("R10 overrun bit", v, 8'h02);
        bus_rd(2'd3, v); chk("R10 flag", v, 8'h02);
        bus_rd(2'd1, v); chk("R10 newest byte", v, 8'h20);
        bus_rd(2'd2, v); chk("R11 overrun cleared", v, 8'h00);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule